// File: doc/BRIEF.md
# Conditional Branch and Call Sequencer

This block is the program-counter engine of a small DSP core. Each cycle it looks at the instruction word fetched from the current address and computes the next address. Words outside the branch class, and branches whose condition fails, advance the counter by one. A branch word selects one of several forms: a jump to an encoded address, a jump through a datapath register, a call to either kind of target, a subroutine return, or a return from interrupt. Every form, returns included, is gated by a five-bit condition tested against the zero and negative flags from the datapath.

Return addresses live in a hardware stack. By default the stack holds eight entries. Each entry stores an address and a two-bit flag snapshot. An interrupt request takes priority over the instruction in the same cycle. When the stack has room, the interrupt saves the current address with the flags and redirects the counter to a fixed vector. Return from interrupt hands the saved flags back to the datapath on a one-cycle restore strobe. A push onto a full stack or a pop from an empty one is refused, and it raises a sticky error flag that only reset clears.

Top module: `brcall_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, the PC is `RESET_PC` (default 0x0000), the stack is empty (depth 0), the error flag is low and the restore strobe is low.
- R2: A word whose bits [31:25] differ from 1011111 advances the PC by one. So does a branch word of reserved type 4 or 6, and so does any branch whose condition is false. None of these changes the stack.
- R3: Bits [24:20] of a branch word hold the condition. With the low four bits as the base: 0 tests Z, 1 tests (not Z and not N), 2 tests N, and every other base value is false (base 6 is the defined "never"). Bit 24 inverts the result, so code 0x16 means always.
- R4: Bits [19:17] hold the type, and bits [15:0] hold the target. Type 0 with a true condition loads the PC with bits [15:0].
- R5: An indirect form (type 1 or 3) is valid when bits [15:8] equal 0x40. Its register selector `ind_sel` always shows bits [7:0] in the same cycle, and its target is `ind_val`. An indirect form whose bits [15:8] differ from 0x40 advances the PC by one and does not touch the stack.
- R6: A taken call (type 2 absolute, type 3 indirect) with room on the stack pushes PC+1 and loads the target. The stack depth then rises by one.
- R7: A taken return (type 5) on a non-empty stack loads the most recently pushed address and lowers the depth by one. The stack holds `STACK_DEPTH` (default 8) entries, and `stk_full` is high when all of them are used.
- R8: When `irq` is high and the stack is not full, the instruction word in that cycle is not executed. Instead the current PC and the flags {Z,N} are pushed, and the PC becomes `IRQ_VEC` (default 0x0100).
- R9: A taken return from interrupt (type 7) on a non-empty stack pops into the PC. On the next cycle `flag_rst_vld` pulses for one cycle with the saved Z and N.
- R10: A call, or an interrupt request, while the stack is full sets `stk_err`. So does a taken return or return from interrupt while the stack is empty. The stack stays unchanged. A refused instruction advances the PC by one, and a refused interrupt lets the instruction execute normally. `stk_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word at the current PC |
| flag_z | input | 1 | Zero flag from the datapath |
| flag_n | input | 1 | Negative flag from the datapath |
| irq | input | 1 | Interrupt request |
| ind_val | input | 16 | Value of the register named by `ind_sel` |
| ind_sel | output | 8 | Register selector for indirect forms |
| pc | output | 16 | Program counter |
| sp_depth | output | 4 | Number of occupied stack entries |
| stk_full | output | 1 | Stack has no free entry |
| stk_empty | output | 1 | Stack holds no entry |
| stk_err | output | 1 | Sticky overflow/underflow flag |
| flag_rst_vld | output | 1 | One-cycle strobe to restore flags |
| flag_rst_z | output | 1 | Restored zero flag |
| flag_rst_n | output | 1 | Restored negative flag |

## Verification
The PC, stack depth, full/empty status and error flag each take one register stage, so each one is due on the clock edge right after the word, flags and request are presented. The restore strobe comes one edge after the return from interrupt that pops. `ind_sel` is combinational and is due in the same cycle. The bench drives inputs on the falling edge and advances its own model by one step at the same point. At the next falling edge it compares every output, so each result is sampled half a period after the single register that produces it.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

    localparam int ADDR_W = 16;
    localparam int WORD_W = 32;
    localparam logic [6:0] BR_OPC = 7'b1011111;
    localparam logic [7:0] IND_TAG = 8'h40;

    typedef enum logic [2:0] {
        BK_JMP   = 3'd0,
        BK_JMPI  = 3'd1,
        BK_CALL  = 3'd2,
        BK_CALLI = 3'd3,
        BK_RSV4  = 3'd4,
        BK_RET   = 3'd5,
        BK_RSV6  = 3'd6,
        BK_RETI  = 3'd7
    } br_kind_e;

    typedef struct packed {
        logic              is_br;
        logic [4:0]        cond;
        br_kind_e          kind;
        logic [ADDR_W-1:0] tgt;
        logic              ind_ok;
        logic [7:0]        reg_sel;
    } br_dec_t;

    function automatic br_dec_t split_word(logic [WORD_W-1:0] w);
        br_dec_t d;
        d.is_br   = (w[31:25] == BR_OPC);
        d.cond    = w[24:20];
        d.kind    = br_kind_e'(w[19:17]);
        d.tgt     = w[15:0];
        d.ind_ok  = (w[15:8] == IND_TAG);
        d.reg_sel = w[7:0];
        return d;
    endfunction

    function automatic logic test_cond(logic [4:0] c, logic z, logic n);
        logic base;
        case (c[3:0])
            4'h0:    base = z;
            4'h1:    base = !z && !n;
            4'h2:    base = n;
            default: base = 1'b0;
        endcase
        return base ^ c[4];
    endfunction

endpackage

// File: rtl/brseq_decode.sv
module brseq_decode
    import brseq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              z,
    input  logic              n,
    output br_dec_t           dec,
    output logic              taken
);
    always_comb begin
        dec   = split_word(word);
        taken = dec.is_br && test_cond(dec.cond, z, n);
    end
endmodule

// File: rtl/brseq_rstack.sv
module brseq_rstack #(
    parameter int DEPTH = 8,
    parameter int DW    = 18
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              din,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [IW-1:0] top_idx;

    assign count   = cnt;
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = IW'(cnt - CW'(1));
    assign dout    = empty ? '0 : mem[top_idx];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push && !full && cnt == CW'(i))
                mem[i] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + CW'(1);
        else if (pop && !empty)
            cnt <= cnt - CW'(1);
    end

    p_depth_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    p_push_grow_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (cnt == $past(cnt) + CW'(1)));
    p_full_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(cnt));
    p_empty_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/brcall_seq.sv
module brcall_seq
    import brseq_pkg::*;
#(
    parameter int               STACK_DEPTH = 8,
    parameter logic [15:0]      RESET_PC    = 16'h0000,
    parameter logic [15:0]      IRQ_VEC     = 16'h0100
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [31:0]                      instr,
    input  logic                             flag_z,
    input  logic                             flag_n,
    input  logic                             irq,
    input  logic [15:0]                      ind_val,
    output logic [7:0]                       ind_sel,
    output logic [15:0]                      pc,
    output logic [$clog2(STACK_DEPTH+1)-1:0] sp_depth,
    output logic                             stk_full,
    output logic                             stk_empty,
    output logic                             stk_err,
    output logic                             flag_rst_vld,
    output logic                             flag_rst_z,
    output logic                             flag_rst_n
);
    localparam int EW = ADDR_W + 2;

    br_dec_t          dec;
    logic             taken;
    logic             push, pop, err_set, rest_set;
    logic [EW-1:0]    push_data, top_data;
    logic [ADDR_W-1:0] pc_q, pc_nxt, pc_inc;

    brseq_decode u_dec (
        .word  (instr),
        .z     (flag_z),
        .n     (flag_n),
        .dec   (dec),
        .taken (taken)
    );

    brseq_rstack #(.DEPTH(STACK_DEPTH), .DW(EW)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (push_data),
        .dout  (top_data),
        .count (sp_depth),
        .full  (stk_full),
        .empty (stk_empty)
    );

    assign ind_sel = dec.reg_sel;
    assign pc      = pc_q;
    assign pc_inc  = pc_q + ADDR_W'(1);

    always_comb begin
        pc_nxt    = pc_inc;
        push      = 1'b0;
        pop       = 1'b0;
        err_set   = 1'b0;
        rest_set  = 1'b0;
        push_data = {flag_z, flag_n, pc_inc};
        if (irq && !stk_full) begin
            push      = 1'b1;
            push_data = {flag_z, flag_n, pc_q};
            pc_nxt    = IRQ_VEC;
        end else begin
            if (irq)
                err_set = 1'b1;
            if (taken) begin
                case (dec.kind)
                    BK_JMP:  pc_nxt = dec.tgt;
                    BK_JMPI: if (dec.ind_ok) pc_nxt = ind_val;
                    BK_CALL, BK_CALLI: begin
                        if (dec.kind == BK_CALL || dec.ind_ok) begin
                            if (stk_full) begin
                                err_set = 1'b1;
                            end else begin
                                push   = 1'b1;
                                pc_nxt = (dec.kind == BK_CALL) ? dec.tgt : ind_val;
                            end
                        end
                    end
                    BK_RET, BK_RETI: begin
                        if (stk_empty) begin
                            err_set = 1'b1;
                        end else begin
                            pop      = 1'b1;
                            pc_nxt   = top_data[ADDR_W-1:0];
                            rest_set = (dec.kind == BK_RETI);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q         <= RESET_PC;
            stk_err      <= 1'b0;
            flag_rst_vld <= 1'b0;
            flag_rst_z   <= 1'b0;
            flag_rst_n   <= 1'b0;
        end else begin
            pc_q         <= pc_nxt;
            stk_err      <= stk_err | err_set;
            flag_rst_vld <= rest_set;
            if (rest_set) begin
                flag_rst_z <= top_data[EW-1];
                flag_rst_n <= top_data[EW-2];
            end
        end
    end

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err);
    p_irq_vector_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !stk_full) |=> (pc == IRQ_VEC));
    p_plain_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!irq && instr[31:25] != BR_OPC) |=> (pc == $past(pc) + 16'd1));
    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC && stk_empty && !stk_err));
    p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        flag_rst_vld |-> $past(instr[31:25] == BR_OPC && instr[19:17] == 3'd7));
endmodule

// File: tb/brcall_seq_tb.sv
`timescale 1ns/1ps
module brcall_seq_tb;
    localparam int DEP = 8;
    localparam logic [15:0] VEC = 16'h0100;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        flag_z, flag_n, irq;
    logic [15:0] ind_val;
    logic [7:0]  ind_sel;
    logic [15:0] pc;
    logic [3:0]  sp_depth;
    logic        stk_full, stk_empty, stk_err;
    logic        flag_rst_vld, flag_rst_z, flag_rst_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    brcall_seq u_dut (
        .clk(clk), .rst(rst), .instr(instr), .flag_z(flag_z), .flag_n(flag_n),
        .irq(irq), .ind_val(ind_val), .ind_sel(ind_sel), .pc(pc),
        .sp_depth(sp_depth), .stk_full(stk_full), .stk_empty(stk_empty),
        .stk_err(stk_err), .flag_rst_vld(flag_rst_vld),
        .flag_rst_z(flag_rst_z), .flag_rst_n(flag_rst_n)
    );

    logic [17:0] m_stk [DEP];
    int          m_cnt;
    logic [15:0] m_pc;
    logic        m_err, m_rv, m_rz, m_rn;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic cond_ok(logic [4:0] c, logic z, logic n);
        logic r;
        r = (c[3:0] == 4'h0) ? z :
            (c[3:0] == 4'h1) ? (!z && !n) :
            (c[3:0] == 4'h2) ? n : 1'b0;
        return c[4] ? !r : r;
    endfunction

    function automatic logic [31:0] mk_br(logic [4:0] c, logic [2:0] t, logic [15:0] a);
        return {7'b1011111, c, t, 1'b0, a};
    endfunction

    task automatic m_reset();
        m_cnt = 0; m_pc = 16'h0000; m_err = 0; m_rv = 0; m_rz = 0; m_rn = 0;
    endtask

    task automatic m_step(input logic [31:0] w, input logic z, input logic n,
                          input logic rq, input logic [15:0] iv);
        logic [15:0] nx;
        logic        isb, ok, ind;
        logic [2:0]  t;
        nx  = m_pc + 16'd1;
        isb = (w[31:25] == 7'b1011111);
        t   = w[19:17];
        ind = (w[15:8] == 8'h40);
        ok  = isb && cond_ok(w[24:20], z, n);
        m_rv = 0;
        if (rq && m_cnt < DEP) begin
            m_stk[m_cnt] = {z, n, m_pc}; m_cnt++; nx = VEC;
        end else begin
            if (rq) m_err = 1;
            if (ok) begin
                if (t == 3'd0) nx = w[15:0];
                else if (t == 3'd1 && ind) nx = iv;
                else if ((t == 3'd2) || (t == 3'd3 && ind)) begin
                    if (m_cnt == DEP) m_err = 1;
                    else begin
                        m_stk[m_cnt] = {z, n, m_pc + 16'd1}; m_cnt++;
                        nx = (t == 3'd2) ? w[15:0] : iv;
                    end
                end else if (t == 3'd5 || t == 3'd7) begin
                    if (m_cnt == 0) m_err = 1;
                    else begin
                        m_cnt--; nx = m_stk[m_cnt][15:0];
                        if (t == 3'd7) begin
                            m_rv = 1; m_rz = m_stk[m_cnt][17]; m_rn = m_stk[m_cnt][16];
                        end
                    end
                end
            end
        end
        m_pc = nx;
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " pc"}, pc, m_pc);
        chk({tag, " depth"}, sp_depth, m_cnt);
        chk({tag, " full"}, stk_full, m_cnt == DEP);
        chk({tag, " empty"}, stk_empty, m_cnt == 0);
        chk({tag, " err"}, stk_err, m_err);
        chk({tag, " rvld"}, flag_rst_vld, m_rv);
        if (m_rv) chk({tag, " rflags"}, {flag_rst_z, flag_rst_n}, {m_rz, m_rn});
    endtask

    task automatic cyc(input logic [31:0] w, input logic z, input logic n,
                       input logic rq, input logic [15:0] iv, input string tag);
        instr = w; flag_z = z; flag_n = n; irq = rq; ind_val = iv;
        #1;
        chk("R5 ind_sel", ind_sel, w[7:0]);
        m_step(w, z, n, rq, iv);
        @(negedge clk);
        cmp_all(tag);
    endtask

    task automatic do_reset();
        rst = 1; instr = 32'h0; irq = 0; flag_z = 0; flag_n = 0; ind_val = 0;
        repeat (2) @(negedge clk);
        m_reset();
        cmp_all("R1 reset-held");
        rst = 0;
    endtask

    function automatic logic [31:0] rnd_word();
        logic [4:0]  codes [8] = '{5'h00, 5'h01, 5'h02, 5'h06, 5'h10, 5'h11, 5'h12, 5'h16};
        logic [31:0] w;
        logic [15:0] a;
        logic [4:0]  c;
        if ($urandom % 10 < 3) begin
            w = $urandom;
            if (w[31:25] == 7'b1011111) w[25] = 1'b0;
            return w;
        end
        c = ($urandom % 5 == 0) ? 5'($urandom) : codes[$urandom % 8];
        a = ($urandom % 2 == 0) ? {8'h40, 8'($urandom)} : 16'($urandom);
        return mk_br(c, 3'($urandom), a);
    endfunction

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        cyc(32'h0, 0, 0, 0, 0, "R1 first-cycle R2");

        // R3/R4 condition forms on absolute jumps
        cyc(mk_br(5'h00, 3'd0, 16'h1234), 1, 0, 0, 0, "R3 R4 eq-taken");
        chk("R4 jump target", pc, 16'h1234);
        cyc(mk_br(5'h10, 3'd0, 16'h2000), 1, 0, 0, 0, "R3 ne-not-taken");
        chk("R3 ne advance", pc, 16'h1235);
        cyc(mk_br(5'h06, 3'd0, 16'h3000), 1, 1, 0, 0, "R3 never");
        cyc(mk_br(5'h16, 3'd0, 16'h3000), 0, 0, 0, 0, "R3 always");
        chk("R3 always jumps", pc, 16'h3000);
        cyc(mk_br(5'h01, 3'd0, 16'h3100), 0, 0, 0, 0, "R3 gt");
        cyc(mk_br(5'h02, 3'd0, 16'h3200), 0, 1, 0, 0, "R3 lt");
        cyc(mk_br(5'h12, 3'd0, 16'h3300), 0, 1, 0, 0, "R3 ge-false");
        // R2 reserved types
        cyc(mk_br(5'h16, 3'd4, 16'h5555), 0, 0, 0, 0, "R2 rsv4");
        cyc(mk_br(5'h16, 3'd6, 16'h5555), 0, 0, 0, 0, "R2 rsv6");
        // R5 indirect
        cyc(mk_br(5'h16, 3'd1, 16'h4007), 0, 0, 0, 16'hbeef, "R5 ind-jump");
        chk("R5 ind target", pc, 16'hbeef);
        cyc(mk_br(5'h16, 3'd1, 16'h4107), 0, 0, 0, 16'h9999, "R5 bad-tag");
        // R6/R10 fill stack then overflow
        for (int i = 0; i < DEP + 1; i++)
            cyc(mk_br(5'h16, 3'd2, 16'h0400 + 16'(i)), 0, 0, 0, 0, "R6 R10 call-fill");
        chk("R10 overflow err", stk_err, 1'b1);
        chk("R7 full depth", sp_depth, DEP);
        cyc(32'h0, 1, 0, 1, 0, "R10 irq-on-full");
        for (int i = 0; i < DEP; i++)
            cyc(mk_br(5'h16, 3'd5, 16'h0), 0, 0, 0, 0, "R7 ret-drain");
        // R10 underflow after fresh reset
        do_reset();
        cyc(mk_br(5'h16, 3'd5, 16'h0), 0, 0, 0, 0, "R10 pop-empty");
        chk("R10 underflow err", stk_err, 1'b1);
        chk("R10 pc advance", pc, 16'h0001);
        // R8/R9 interrupt then return
        do_reset();
        cyc(mk_br(5'h16, 3'd0, 16'h0777), 1, 0, 1, 0, "R8 irq-wins");
        chk("R8 vector", pc, VEC);
        cyc(mk_br(5'h16, 3'd7, 16'h0), 0, 1, 0, 0, "R9 reti");
        chk("R9 return addr", pc, 16'h0000);
        chk("R9 restore strobe", flag_rst_vld, 1'b1);
        chk("R9 restored flags", {flag_rst_z, flag_rst_n}, 2'b10);
        cyc(32'h0, 0, 0, 0, 0, "R9 strobe-drop");
        // random mix
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            if (k % 700 == 699) do_reset();
            cyc(rnd_word(), 1'($urandom), 1'($urandom), ($urandom % 12 == 0),
                16'($urandom), "R2 R3 R6 R7 R8 R9 R10 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule